// File: doc/BRIEF.md
# Word Block Copy Engine

This engine copies a run of 32-bit words from a source region to a destination region with no processor in the loop. It drives two bus masters, one that only reads the source and one that only writes the destination, and it is programmed through a small register port. Words move from the read side to the write side through a shallow internal FIFO. Each side can stall the other: the read side stops when the FIFO has no room, and the write side waits while the FIFO is empty.

Software programs the two sides on their own. The fetch side gets a start address and a byte length, and the store side gets a start address and a byte length. Either side can be armed at any time. Data moves only once both sides are armed. Completion is tracked on the store side. When the last word has been stored, a done flag is set, and an interrupt is raised if it is enabled. Software clears done and then arms the next transfer. A long copy can therefore be done as a series of short chunks, for example 40 bytes at a time.

Top module: `dma_wordcopy`

## Requirements
- R1: After reset every register reads zero, both masters are idle and `irq` is low.
- R2: Register offsets on `cfg_addr` are: 0 fetch address, 1 fetch byte length, 2 store address, 3 store byte length, 4 control {bit2 irq enable, bit1 store armed, bit0 fetch armed}, 5 status {bit1 busy, bit0 done}. A read returns the value in the same cycle that `cfg_rd` is high. `cfg_rdata` is zero while `cfg_rd` is low.
- R3: Writing 1 to control bit 0 arms the fetch side and writing 1 to bit 1 arms the store side. Writing 0 to either bit does not disarm that side. No bus traffic occurs until both sides are armed. Both arm flags clear when a transfer starts.
- R4: Word i is read from fetch address + 4·i and written unchanged to store address + 4·i, with i rising from 0.
- R5: The number of words moved is the smaller of the two byte lengths divided by four.
- R6: If either length is zero or is not a multiple of four, done is set without any bus traffic.
- R7: At most one read is outstanding at a time. The FIFO holds 4 words. With the store side stalled, exactly 5 reads are accepted (4 in the FIFO and 1 held on the write master) before fetching stops.
- R8: While `rm_wait` is high, a pending read keeps `rm_read` and `rm_addr` steady. While `wm_wait` is high, a pending write keeps `wm_write`, `wm_addr` and `wm_wdata` steady.
- R9: Busy rises when a valid transfer starts, and the start clears done. When the final write is accepted, busy falls and done rises. Writing 1 to status bit 0 clears done.
- R10: `irq` is high exactly while done and the irq enable are both set.
- R11: Rewriting the address or length registers while a transfer runs does not change that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 3 | Register word offset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rd | input | 1 | Register read strobe |
| cfg_rdata | output | 32 | Register read data, same cycle |
| rm_addr | output | AW | Fetch master byte address |
| rm_read | output | 1 | Fetch master read request |
| rm_wait | input | 1 | Fetch master stall |
| rm_rdata | input | 32 | Fetch master returned word |
| rm_rvalid | input | 1 | Returned word valid, at least one cycle after acceptance |
| wm_addr | output | AW | Store master byte address |
| wm_write | output | 1 | Store master write request |
| wm_wdata | output | 32 | Store master write word |
| wm_wait | input | 1 | Store master stall |
| irq | output | 1 | Completion interrupt |

## Verification
A register write takes effect at the next edge. An arm write starts the transfer one edge later, so busy, or done for a bad length, is visible two edges after the control write. Done appears one edge after the final write handshake, `irq` follows done within the same cycle, and status reads are combinational. The bench keeps its own model of these latencies, advanced once per cycle from the handshakes it saw at the previous edge. It compares status, interrupt, request-hold and idle behaviour on every falling edge, and it checks each read and write handshake against a queue of expected addresses and data built when the transfer starts.

// File: rtl/dma_wordcopy.sv
module dma_wordcopy #(
  parameter int AW    = 32,
  parameter int LW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cfg_addr,
  input  logic          cfg_wr,
  input  logic [31:0]   cfg_wdata,
  input  logic          cfg_rd,
  output logic [31:0]   cfg_rdata,
  output logic [AW-1:0] rm_addr,
  output logic          rm_read,
  input  logic          rm_wait,
  input  logic [31:0]   rm_rdata,
  input  logic          rm_rvalid,
  output logic [AW-1:0] wm_addr,
  output logic          wm_write,
  output logic [31:0]   wm_wdata,
  input  logic          wm_wait,
  output logic          irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int NW = LW - 2;
  localparam logic [2:0] A_SRC = 3'd0, A_SLEN = 3'd1, A_DST = 3'd2,
                         A_DLEN = 3'd3, A_CTRL = 3'd4, A_STAT = 3'd5;

  logic [AW-1:0] src_addr, dst_addr, rd_ptr, wr_ptr;
  logic [LW-1:0] src_len, dst_len;
  logic          tx_armed, rx_armed, irq_en, done, busy, rd_pend;
  logic [NW-1:0] rd_left, wr_left;
  logic [31:0]   fifo [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] fcnt;

  logic [LW-1:0] min_len;
  logic bad_len, start, rd_acc, wr_acc, push, pop, rd_issue;

  assign min_len  = (src_len < dst_len) ? src_len : dst_len;
  assign bad_len  = (src_len == '0) | (dst_len == '0) | (|src_len[1:0]) | (|dst_len[1:0]);
  assign start    = tx_armed & rx_armed & ~busy;
  assign rd_acc   = rm_read & ~rm_wait;
  assign wr_acc   = wm_write & ~wm_wait;
  assign push     = rd_pend & rm_rvalid;
  assign pop      = busy & ~wm_write & (fcnt != '0);
  assign rd_issue = busy & ~rm_read & ~rd_pend & (rd_left != '0) & (fcnt < CW'(DEPTH));
  assign rm_addr  = rd_ptr;
  assign wm_addr  = wr_ptr;
  assign irq      = done & irq_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      src_addr <= '0; dst_addr <= '0; src_len <= '0; dst_len <= '0;
      tx_armed <= 1'b0; rx_armed <= 1'b0; irq_en <= 1'b0;
    end else begin
      if (start) begin
        tx_armed <= 1'b0;
        rx_armed <= 1'b0;
      end
      if (cfg_wr)
        case (cfg_addr)
          A_SRC:  src_addr <= AW'(cfg_wdata);
          A_SLEN: src_len  <= LW'(cfg_wdata);
          A_DST:  dst_addr <= AW'(cfg_wdata);
          A_DLEN: dst_len  <= LW'(cfg_wdata);
          A_CTRL: begin
            if (cfg_wdata[0]) tx_armed <= 1'b1;
            if (cfg_wdata[1]) rx_armed <= 1'b1;
            irq_en <= cfg_wdata[2];
          end
          default: ;
        endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      done <= 1'b0; busy <= 1'b0; rd_pend <= 1'b0;
      rd_ptr <= '0; wr_ptr <= '0; rd_left <= '0; wr_left <= '0;
      rm_read <= 1'b0; wm_write <= 1'b0; wm_wdata <= '0;
    end else begin
      if (cfg_wr && cfg_addr == A_STAT && cfg_wdata[0]) done <= 1'b0;
      if (start) begin
        if (bad_len) done <= 1'b1;
        else begin
          busy    <= 1'b1;
          done    <= 1'b0;
          rd_ptr  <= src_addr;
          wr_ptr  <= dst_addr;
          rd_left <= NW'(min_len >> 2);
          wr_left <= NW'(min_len >> 2);
        end
      end
      if (rd_issue) rm_read <= 1'b1;
      if (rd_acc) begin
        rm_read <= 1'b0;
        rd_pend <= 1'b1;
        rd_ptr  <= rd_ptr + AW'(4);
        rd_left <= rd_left - 1'b1;
      end
      if (push) rd_pend <= 1'b0;
      if (pop) begin
        wm_write <= 1'b1;
        wm_wdata <= fifo[head];
      end
      if (wr_acc) begin
        wm_write <= 1'b0;
        wr_ptr   <= wr_ptr + AW'(4);
        wr_left  <= wr_left - 1'b1;
        if (wr_left == NW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      head <= '0; tail <= '0; fcnt <= '0;
    end else begin
      if (push) tail <= tail + 1'b1;
      if (pop)  head <= head + 1'b1;
      fcnt <= fcnt + CW'(push) - CW'(pop);
    end

  always_ff @(posedge clk)
    if (push) fifo[tail] <= rm_rdata;

  always_comb begin
    cfg_rdata = '0;
    if (cfg_rd)
      case (cfg_addr)
        A_SRC:  cfg_rdata = 32'(src_addr);
        A_SLEN: cfg_rdata = 32'(src_len);
        A_DST:  cfg_rdata = 32'(dst_addr);
        A_DLEN: cfg_rdata = 32'(dst_len);
        A_CTRL: cfg_rdata = {29'd0, irq_en, rx_armed, tx_armed};
        A_STAT: cfg_rdata = {30'd0, busy, done};
        default: ;
      endcase
  end

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (fcnt < CW'(DEPTH)));
  a_r7_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    rm_read |-> !rd_pend);
  a_r8_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rm_read && rm_wait) |=> (rm_read && $stable(rm_addr)));
  a_r8_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wm_write && wm_wait) |=> (wm_write && $stable(wm_addr) && $stable(wm_wdata)));
  a_r9_busy_excl_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rm_read && !wm_write));
endmodule

// File: tb/test_dma_wordcopy.sv
module test_dma_wordcopy;
  localparam int AW = 32, LW = 16, DEPTH = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [2:0] cfg_addr;
  logic cfg_wr, cfg_rd;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic [AW-1:0] rm_addr, wm_addr;
  logic rm_read, rm_wait, rm_rvalid, wm_write, wm_wait, irq;
  logic [31:0] rm_rdata, wm_wdata;

  dma_wordcopy #(.AW(AW), .LW(LW), .DEPTH(DEPTH)) i_dma_wordcopy (
    .clk(clk), .rst_n(rst_n),
    .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata),
    .rm_addr(rm_addr), .rm_read(rm_read), .rm_wait(rm_wait),
    .rm_rdata(rm_rdata), .rm_rvalid(rm_rvalid),
    .wm_addr(wm_addr), .wm_write(wm_write), .wm_wdata(wm_wdata),
    .wm_wait(wm_wait), .irq(irq));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] src_word(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  // reference model state
  bit m_txa, m_rxa, m_ien, m_busy, m_done;
  logic [31:0] m_src, m_dst;
  int m_slen, m_dlen;
  logic [63:0] exp_w[$];
  logic [31:0] exp_r[$];
  int tot_rd, tot_wr;
  // bus responder state
  bit stall_mode, wstall, rpend;
  int cur_lat, lat;
  logic [31:0] rpend_addr;
  logic [7:0] lfsr;
  bit p_rm_read, p_rwait, p_wm_write, p_wwait;
  logic [31:0] p_rm_addr, p_wm_addr, p_wm_data;
  logic c_wr;
  logic [2:0] c_addr;
  logic [31:0] c_data;
  int cycles;

  always @(posedge clk) begin
    c_wr   <= cfg_wr;
    c_addr <= cfg_addr;
    c_data <= cfg_wdata;
  end

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(negedge clk) begin : mon
    bit st, bad;
    int mn;
    logic [63:0] e;
    if (!rst_n) begin
      m_txa = 0; m_rxa = 0; m_ien = 0; m_busy = 0; m_done = 0;
      m_src = 0; m_dst = 0; m_slen = 0; m_dlen = 0;
      rm_wait = 0; wm_wait = 0; rm_rvalid = 0; rm_rdata = 0; rpend = 0;
      p_rm_read = 0; p_rwait = 0; p_wm_write = 0; p_wwait = 0;
      p_rm_addr = 0; p_wm_addr = 0; p_wm_data = 0; lfsr = 8'hA5;
    end else begin
      // model the edge that just passed
      st = m_txa && m_rxa && !m_busy;
      if (c_wr && c_addr == 3'd5 && c_data[0]) m_done = 0;
      if (st) begin
        m_txa = 0; m_rxa = 0;
        bad = (m_slen == 0) || (m_dlen == 0) || (m_slen % 4 != 0) || (m_dlen % 4 != 0);
        if (bad) m_done = 1;
        else begin
          m_busy = 1; m_done = 0;
          mn = (m_slen < m_dlen) ? m_slen : m_dlen;
          for (int i = 0; i < mn / 4; i++) begin
            exp_r.push_back(m_src + 32'(4 * i));
            exp_w.push_back({m_dst + 32'(4 * i), src_word(m_src + 32'(4 * i))});
          end
        end
      end
      if (c_wr)
        case (c_addr)
          3'd0: m_src = c_data;
          3'd1: m_slen = int'(c_data[LW-1:0]);
          3'd2: m_dst = c_data;
          3'd3: m_dlen = int'(c_data[LW-1:0]);
          3'd4: begin
            if (c_data[0]) m_txa = 1;
            if (c_data[1]) m_rxa = 1;
            m_ien = c_data[2];
          end
          default: ;
        endcase
      if (p_rm_read && !p_rwait) begin
        if (exp_r.size() == 0) chk(0, "R4 unexpected read", 64'(p_rm_addr), 0);
        else begin
          chk(p_rm_addr == exp_r[0], "R4 read address", 64'(p_rm_addr), 64'(exp_r[0]));
          void'(exp_r.pop_front());
        end
        tot_rd++;
        rpend = 1; lat = cur_lat; rpend_addr = p_rm_addr;
      end
      if (p_wm_write && !p_wwait) begin
        if (exp_w.size() == 0) chk(0, "R4 unexpected write", 64'(p_wm_addr), 0);
        else begin
          e = exp_w.pop_front();
          chk({p_wm_addr, p_wm_data} == e, "R4 write addr/data", {p_wm_addr, p_wm_data}, e);
          if (exp_w.size() == 0) begin m_busy = 0; m_done = 1; end
        end
        tot_wr++;
      end
      #2;
      if (cfg_rd && !cfg_wr && cfg_addr == 3'd5)
        chk(cfg_rdata[1:0] == {m_busy, m_done}, "R9 status", 64'(cfg_rdata), {62'd0, m_busy, m_done});
      chk(irq == (m_done && m_ien), "R10 irq", 64'(irq), 64'(m_done && m_ien));
      if (!m_busy) chk(!rm_read && !wm_write, "R3 no traffic while idle", {rm_read, wm_write}, 0);
      chk(tot_rd - tot_wr <= DEPTH + 1, "R7 words in flight", 64'(tot_rd - tot_wr), DEPTH + 1);
      if (p_rm_read && p_rwait)
        chk(rm_read && rm_addr == p_rm_addr, "R8 read hold", {rm_read, rm_addr}, {1'b1, p_rm_addr});
      if (p_wm_write && p_wwait)
        chk(wm_write && wm_addr == p_wm_addr && wm_wdata == p_wm_data, "R8 write hold",
            {wm_addr, wm_wdata}, {p_wm_addr, p_wm_data});
      // drive the responders for the next edge
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rm_wait = stall_mode & lfsr[0] & lfsr[2];
      wm_wait = wstall | (stall_mode & lfsr[3]);
      rm_rvalid = 0;
      if (rpend) begin
        if (lat == 0) begin
          rm_rvalid = 1; rm_rdata = src_word(rpend_addr); rpend = 0;
        end else lat--;
      end
      p_rm_read = rm_read; p_rwait = rm_wait; p_rm_addr = rm_addr;
      p_wm_write = wm_write; p_wwait = wm_wait; p_wm_addr = wm_addr; p_wm_data = wm_wdata;
      cycles++;
      if (cycles > 150000) begin
        chk(0, "watchdog", 64'(cycles), 150000);
        finish_up();
      end
    end
  end

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_rd = 0; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0; cfg_rd = 1; cfg_addr = 3'd5;
  endtask

  task automatic cfg_read(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    cfg_wr = 0; cfg_rd = 1; cfg_addr = a;
    #1 v = cfg_rdata;
    cfg_addr = 3'd5;
  endtask

  task automatic xfer(input logic [31:0] s, input int sl, input logic [31:0] d, input int dl, input bit ien);
    cfg_write(3'd0, s);
    cfg_write(3'd1, 32'(sl));
    cfg_write(3'd2, d);
    cfg_write(3'd3, 32'(dl));
    cfg_write(3'd4, {29'd0, ien, 2'b11});
  endtask

  task automatic wait_done;
    do begin @(negedge clk); #3; end while (cfg_rdata[0] !== 1'b1);
  endtask

  initial begin
    logic [31:0] v;
    int w0, r0;
    rst_n = 0; cfg_wr = 0; cfg_rd = 1; cfg_addr = 3'd5; cfg_wdata = 0;
    stall_mode = 0; wstall = 0; cur_lat = 0; tot_rd = 0; tot_wr = 0; cycles = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      cfg_read(3'(a), v);
      chk(v == 0, "R1 register after reset", 64'(v), 0);
    end
    chk(!irq && !rm_read && !wm_write, "R1 outputs after reset", {irq, rm_read, wm_write}, 0);

    // R2: register readback
    cfg_write(3'd0, 32'h1234_5678); cfg_write(3'd1, 32'h0000_ABCD);
    cfg_write(3'd2, 32'h8765_4321); cfg_write(3'd3, 32'h0000_0F0C);
    cfg_read(3'd0, v); chk(v == 32'h1234_5678, "R2 fetch address", 64'(v), 64'h1234_5678);
    cfg_read(3'd1, v); chk(v == 32'h0000_ABCD, "R2 fetch length", 64'(v), 64'hABCD);
    cfg_read(3'd2, v); chk(v == 32'h8765_4321, "R2 store address", 64'(v), 64'h8765_4321);
    cfg_read(3'd3, v); chk(v == 32'h0000_0F0C, "R2 store length", 64'(v), 64'h0F0C);
    @(negedge clk); cfg_rd = 0; cfg_addr = 3'd0; #1;
    chk(cfg_rdata == 0, "R2 data zero without read strobe", 64'(cfg_rdata), 0);
    cfg_rd = 1; cfg_addr = 3'd5;

    // R3: only the fetch side armed
    cfg_write(3'd0, 32'h1000); cfg_write(3'd1, 40);
    cfg_write(3'd2, 32'h8000); cfg_write(3'd3, 40);
    r0 = tot_rd;
    cfg_write(3'd4, 32'h5);
    repeat (20) @(negedge clk);
    #3 chk(tot_rd == r0, "R3 no reads with one side armed", 64'(tot_rd), 64'(r0));
    cfg_write(3'd4, 32'h4);
    cfg_read(3'd4, v); chk(v == 32'h5, "R3 writing zero keeps arm", 64'(v), 5);
    cfg_write(3'd4, 32'h6);
    wait_done();
    chk(tot_wr == 10, "R3 transfer after both armed", 64'(tot_wr), 10);
    chk(irq == 1, "R10 irq with enable and done", 64'(irq), 1);
    cfg_read(3'd4, v); chk(v == 32'h4, "R3 arms clear at start", 64'(v), 4);
    cfg_write(3'd5, 32'h1);
    @(negedge clk); #3;
    chk(irq == 0, "R10 irq drops on clear", 64'(irq), 0);
    cfg_read(3'd5, v); chk(v == 0, "R9 done cleared", 64'(v), 0);

    // R4 and R8: back-to-back 40-byte chunks with stalls
    stall_mode = 1; cur_lat = 2;
    w0 = tot_wr;
    for (int k = 0; k < 3; k++) begin
      xfer(32'h2000 + 32'(40 * k), 40, 32'h9000 + 32'(40 * k), 40, 1'b0);
      wait_done();
      cfg_read(3'd5, v); chk(v == 1, "R9 done without busy", 64'(v), 1);
      cfg_write(3'd5, 32'h1);
    end
    chk(tot_wr - w0 == 30 && exp_w.size() == 0, "R4 chunked copy complete", 64'(tot_wr - w0), 30);

    // R5: unequal lengths
    stall_mode = 0; cur_lat = 0;
    w0 = tot_wr;
    xfer(32'h4000, 40, 32'hC000, 24, 1'b0);
    wait_done();
    chk(tot_wr - w0 == 6, "R5 smaller count moved", 64'(tot_wr - w0), 6);
    cfg_write(3'd5, 32'h1);
    w0 = tot_wr;
    xfer(32'h4400, 12, 32'hC400, 400, 1'b0);
    wait_done();
    chk(tot_wr - w0 == 3, "R5 fetch side smaller", 64'(tot_wr - w0), 3);
    cfg_write(3'd5, 32'h1);

    // R6: bad lengths
    r0 = tot_rd;
    xfer(32'h5000, 0, 32'hD000, 40, 1'b1);
    repeat (3) @(negedge clk);
    cfg_read(3'd5, v); chk(v == 1, "R6 zero length done", 64'(v), 1);
    chk(tot_rd == r0, "R6 zero length no reads", 64'(tot_rd), 64'(r0));
    cfg_write(3'd5, 32'h1);
    xfer(32'h5000, 40, 32'hD000, 6, 1'b0);
    repeat (3) @(negedge clk);
    cfg_read(3'd5, v); chk(v == 1, "R6 unaligned length done", 64'(v), 1);
    chk(tot_rd == r0, "R6 unaligned length no reads", 64'(tot_rd), 64'(r0));
    cfg_write(3'd5, 32'h1);

    // R7: store side stalled
    wstall = 1;
    r0 = tot_rd; w0 = tot_wr;
    xfer(32'h6000, 160, 32'hE000, 160, 1'b0);
    repeat (60) @(negedge clk);
    #3 chk(tot_rd - r0 == DEPTH + 1, "R7 fetch stops when full", 64'(tot_rd - r0), DEPTH + 1);
    chk(tot_wr == w0, "R7 no writes while stalled", 64'(tot_wr), 64'(w0));
    wstall = 0;
    wait_done();
    chk(tot_wr - w0 == 40, "R7 stalled copy completes", 64'(tot_wr - w0), 40);
    cfg_write(3'd5, 32'h1);

    // R11: reprogram while running
    stall_mode = 1; cur_lat = 1;
    w0 = tot_wr;
    xfer(32'h3000, 32, 32'hA000, 32, 1'b0);
    repeat (3) @(negedge clk);
    cfg_write(3'd0, 32'h7000);
    cfg_write(3'd1, 8);
    cfg_write(3'd2, 32'hB000);
    wait_done();
    chk(tot_wr - w0 == 8, "R11 running transfer unchanged", 64'(tot_wr - w0), 8);
    cfg_read(3'd0, v); chk(v == 32'h7000, "R11 register took new value", 64'(v), 64'h7000);
    cfg_write(3'd5, 32'h1);

    repeat (5) @(negedge clk);
    finish_up();
  end
endmodule